// File: doc/BRIEF.md
# Transition-Cleared Watchdog Timer

This block watches a kick signal from a processor and pulls its active-low watchdog output down when the kick level stays unchanged for a full timeout period. Every rising or falling transition of the kick restarts the count. A separate qualifier reports whether anything drives the kick line at all. While that qualifier is low, the count stays at zero, so a line that is never driven turns the watchdog off. The count is also held at zero while the system reset state is active.

Everything runs on one fast clock. The kick level and its qualifier pass through a synchroniser before edge detection. The timeout is counted in pulses of a timebase strobe `tick`, and the parameter `TIMEOUT_TICKS` sets how many pulses make a timeout. The default of 1600 pulses gives a 1.6 s timeout with a 1 ms strobe. Any clock period shorter than the shortest kick pulse lets the block catch that pulse. A separate supply-low input forces the output low at once and releases it with no added delay. Expiry never drives reset. Any loop from the watchdog output back to reset is built outside the block.

Top module: `wdt_transition_watchdog`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `wdo_n` is 1 and the timer is cleared.
- R2: With the kick driven and steady, `sys_rst` low and the timer cleared, `wdo_n` stays 1 through `TIMEOUT_TICKS-1` strobe pulses. It reads 0 after the strobe pulse numbered `TIMEOUT_TICKS`.
- R3: A rising transition of `kick_lvl` clears the timer and returns `wdo_n` to 1.
- R4: A falling transition of `kick_lvl` clears the timer and returns `wdo_n` to 1.
- R5: While `sys_rst` is 1, the timer stays cleared and `wdo_n` stays 1 for any number of strobe pulses.
- R6: While `kick_drv` is 0, the timer stays cleared and `wdo_n` stays 1 for any number of strobe pulses, whatever `kick_lvl` does.
- R7: Once expired, `wdo_n` stays 0 through further strobe pulses until an edge, `sys_rst` or an undriven kick clears the timer.
- R8: While `supply_low` is 1, `wdo_n` is 0 in the same cycle, whatever the timer state.
- R9: When `supply_low` returns to 0 and the timer has not expired, `wdo_n` is 1 in the same cycle.
- R10: A kick pulse one clock period long is detected and clears an expired timer.
- R11: A kick transition clears the timer on the third rising clock edge after the input changes: two synchroniser stages, then the timer register.
- R12: After a clear, a full `TIMEOUT_TICKS` strobe pulses are needed before the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the synchroniser, edge detector and timer |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| tick | input | 1 | Timebase strobe, one clock cycle wide; each pulse advances the timer |
| kick_lvl | input | 1 | Kick level from the processor (asynchronous) |
| kick_drv | input | 1 | 1 when the kick line is driven, 0 when undriven (asynchronous) |
| sys_rst | input | 1 | System reset state, active high, synchronous to clk |
| supply_low | input | 1 | Supply-low indication, active high, synchronous to clk |
| wdo_n | output | 1 | Active-low watchdog output |

## Verification
The assertions assume that `sys_rst`, `supply_low` and `tick` are synchronous to `clk`. They also assume that `tick` is a single-cycle strobe. Only the kick level and its qualifier may change at arbitrary times, and each new value must last at least one clock period. The bench drives every input on the falling clock edge. It holds each kick value for at least one full cycle, so the synchroniser always captures it. The strobe is either a per-cycle pulse or a random pulse, never a level held by a separate clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // One synchroniser stage carries both kick signals side by side.
    typedef struct packed {
        logic lvl;
        logic drv;
    } kick_pair_t;

endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync
    import wdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick_lvl_i,
    input  logic       kick_drv_i,
    output kick_pair_t sync_o
);

    typedef struct packed {
        kick_pair_t [SYNC_STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain[0].lvl = kick_lvl_i;
        state_d.chain[0].drv = kick_drv_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            state_d.chain[i] = state_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_o = state_q.chain[SYNC_STAGES-1];

    // The last stage must hold the value the previous stage held one cycle before.
    assert_sync_shift_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_o == $past(state_q.chain[SYNC_STAGES-2])));

endmodule

// File: rtl/wdt_edge_detect.sv
module wdt_edge_detect
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  kick_pair_t sync_i,
    input  logic       sys_rst_i,
    output logic       kick_edge_o,
    output logic       clear_o
);

    typedef struct packed {
        logic lvl_prev;
    } edge_state_t;

    edge_state_t state_d, state_q;

    always_comb begin
        state_d          = state_q;
        state_d.lvl_prev = sync_i.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Either direction of a transition counts as a kick.
    assign kick_edge_o = sync_i.lvl ^ state_q.lvl_prev;
    assign clear_o     = sys_rst_i | ~sync_i.drv | kick_edge_o;

    assert_undriven_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i.drv |-> clear_o);

    assert_sysrst_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_i |-> clear_o);

endmodule

// File: rtl/wdt_tick_timer.sv
module wdt_tick_timer #(
    parameter int TIMEOUT_TICKS = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clear_i,
    output logic expired_o
);

    localparam int CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             expired;
    } timer_state_t;

    timer_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d = '0;
        end else if (tick_i && !state_q.expired) begin
            if (state_q.count == LAST) begin
                state_d.expired = 1'b1;
            end else begin
                state_d.count = state_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign expired_o = state_q.expired;

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.count <= LAST);

    assert_expiry_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.expired) |-> $past(tick_i) && !$past(clear_i));

    assert_hold_expired_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.expired && !clear_i) |=> state_q.expired);

    assert_clear_restarts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (state_q.count == '0) && !state_q.expired);

endmodule

// File: rtl/wdt_transition_watchdog.sv
module wdt_transition_watchdog
    import wdt_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1600,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick_lvl,
    input  logic kick_drv,
    input  logic sys_rst,
    input  logic supply_low,
    output logic wdo_n
);

    kick_pair_t kick_sync;
    logic       kick_edge;
    logic       timer_clear;
    logic       timer_expired;

    wdt_kick_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_lvl_i (kick_lvl),
        .kick_drv_i (kick_drv),
        .sync_o     (kick_sync)
    );

    wdt_edge_detect i_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (kick_sync),
        .sys_rst_i   (sys_rst),
        .kick_edge_o (kick_edge),
        .clear_o     (timer_clear)
    );

    wdt_tick_timer #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .clear_i   (timer_clear),
        .expired_o (timer_expired)
    );

    // The supply-low path stays combinational so release has no delay.
    assign wdo_n = ~(timer_expired | supply_low);

    assert_supply_low_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !wdo_n);

    assert_edge_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_edge && kick_sync.drv && !supply_low) |=> (wdo_n || supply_low));

    assert_reset_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !supply_low) |-> wdo_n);

endmodule

// File: tb/test_wdt_transition_watchdog.sv
module test_wdt_transition_watchdog;

    localparam int T = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic kick_lvl = 1'b0;
    logic kick_drv = 1'b0;
    logic sys_rst = 1'b0;
    logic supply_low = 1'b0;
    logic wdo_n;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_transition_watchdog #(
        .TIMEOUT_TICKS(T),
        .SYNC_STAGES(2)
    ) i_wdt_transition_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .kick_lvl   (kick_lvl),
        .kick_drv   (kick_drv),
        .sys_rst    (sys_rst),
        .supply_low (supply_low),
        .wdo_n      (wdo_n)
    );

    // Reference model built from the requirements: two capture stages (R11),
    // a clear from edge, reset or undriven line, and a strobe counter (R2).
    logic m_l1, m_l2, m_l3, m_d1, m_d2, m_exp, m_clr;
    int   m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_l1 <= 0; m_l2 <= 0; m_l3 <= 0; m_d1 <= 0; m_d2 <= 0;
            m_exp <= 0; m_cnt <= 0;
        end else begin
            m_clr = sys_rst | !m_d2 | (m_l2 != m_l3);
            m_l1 <= kick_lvl; m_l2 <= m_l1; m_l3 <= m_l2;
            m_d1 <= kick_drv; m_d2 <= m_d1;
            if (m_clr) begin
                m_cnt <= 0; m_exp <= 0;
            end else if (tick && !m_exp) begin
                if (m_cnt == T - 1) m_exp <= 1;
                else m_cnt <= m_cnt + 1;
            end
        end
    end

    function automatic logic model_wdo();
        return !(m_exp | supply_low);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: wdo_n=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, then compare against the model.
    task automatic step(input logic lv, input logic dv, input logic sr,
                        input logic sl, input logic tk, input string tag);
        @(negedge clk);
        kick_lvl = lv; kick_drv = dv; sys_rst = sr; supply_low = sl; tick = tk;
        #1;
        check(wdo_n, model_wdo(), tag);
    endtask

    task automatic run(input int n, input logic tk, input string tag);
        for (int i = 0; i < n; i++) step(kick_lvl, kick_drv, sys_rst, supply_low, tk, tag);
    endtask

    // Settle into a cleared timer with no strobe pulses.
    task automatic settle_cleared();
        step(kick_lvl, 1, 1, 0, 0, "R5");
        run(3, 0, "R5");
        step(kick_lvl, 1, 0, 0, 0, "R5");
        run(2, 0, "R2");
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd20240611);
        // R1: output high while reset is held
        #2;
        check(wdo_n, 1'b1, "R1");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 1, 0, 0, 1, "R1");
        check(wdo_n, 1'b1, "R1");

        // R2 and R12: exactly T strobe pulses to expire
        settle_cleared();
        run(T - 1, 1, "R2");
        check(wdo_n, 1'b1, "R2");
        step(kick_lvl, 1, 0, 0, 1, "R2");
        step(kick_lvl, 1, 0, 0, 0, "R2");
        check(wdo_n, 1'b0, "R2");

        // R7: stays low through more pulses
        run(20, 1, "R7");
        check(wdo_n, 1'b0, "R7");

        // R3 and R11: rising edge clears on the third clock edge
        step(1, 1, 0, 0, 0, "R3");
        step(1, 1, 0, 0, 0, "R11");
        step(1, 1, 0, 0, 0, "R11");
        check(wdo_n, 1'b0, "R11");
        step(1, 1, 0, 0, 0, "R11");
        check(wdo_n, 1'b1, "R3");

        // R12: full period again after the clear
        run(T - 2, 1, "R12");
        check(wdo_n, 1'b1, "R12");
        run(4, 1, "R12");
        check(wdo_n, 1'b0, "R12");

        // R4: falling edge clears
        step(0, 1, 0, 0, 0, "R4");
        run(4, 0, "R4");
        check(wdo_n, 1'b1, "R4");

        // R10: one-clock pulse clears an expired timer
        run(T + 3, 1, "R10");
        check(wdo_n, 1'b0, "R10");
        step(1, 1, 0, 0, 0, "R10");
        step(0, 1, 0, 0, 0, "R10");
        run(4, 0, "R10");
        check(wdo_n, 1'b1, "R10");

        // R5: reset state holds the timer cleared
        step(kick_lvl, 1, 1, 0, 1, "R5");
        run(3 * T, 1, "R5");
        check(wdo_n, 1'b1, "R5");
        step(kick_lvl, 1, 0, 0, 0, "R5");

        // R6: undriven line disables the watchdog, level changes ignored
        step(kick_lvl, 0, 0, 0, 1, "R6");
        for (int i = 0; i < 3 * T; i++) step(i[2], 0, 0, 0, 1, "R6");
        check(wdo_n, 1'b1, "R6");
        step(0, 1, 0, 0, 0, "R6");
        run(3, 0, "R6");

        // R8 and R9: supply-low forces low, release is immediate
        step(kick_lvl, 1, 0, 1, 0, "R8");
        check(wdo_n, 1'b0, "R8");
        run(3, 1, "R8");
        step(kick_lvl, 1, 0, 0, 0, "R9");
        check(wdo_n, 1'b1, "R9");

        // Random phase checked each cycle against the model
        for (int i = 0; i < 4000; i++) begin
            logic lv, dv, sr, sl, tk;
            lv = ($urandom % 40 == 0) ? ~kick_lvl : kick_lvl;
            dv = ($urandom % 60 == 0) ? ~kick_drv : kick_drv;
            sr = ($urandom % 80 == 0);
            sl = ($urandom % 50 == 0);
            tk = ($urandom % 2 == 0);
            step(lv, dv, sr, sl, tk, "R7");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule